// File: doc/BRIEF.md
# Compare-and-Branch Control Unit

This block keeps a processor's relation flags and works out where the program counter goes next. An instruction presented to it is a compare, a branch, or anything else. A compare takes two unsigned operands and records exactly one of three relations: equal, greater or less. A branch tests one of eight condition codes against the flags held from earlier compares. When the condition holds, the unit steers the program counter to a register-relative target. In every other case the counter moves on by one instruction word.

The next PC and the taken indication are combinational functions of the current instruction and the held flags. The flags and a sticky halt state are registered. Once halt is raised, the unit freezes both the counter and the flags until the next reset.

Top module: `cbr_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `flags_o` is 3'b000 and `halted_o` is 0.
- R2: An accepted compare (`op_i` = 2'b01) treats `opa_i` and `opb_i` as unsigned. From the following cycle, `flags_o` has exactly one bit set: bit 0 when a == b, bit 1 when a > b, bit 2 when a < b.
- R3: Only an accepted compare changes `flags_o`. An instruction is accepted when `instr_valid_i` is 1, `halt_i` is 0 and `halted_o` is 0. Branches, other operations, idle cycles and halted cycles leave the flags unchanged.
- R4: For a branch (`op_i` = 2'b10), `cond_i` selects the condition: 0 always, 1 equal set, 2 equal clear, 3 greater set, 4 greater or equal set, 5 less set, 6 less or equal set, 7 never. `taken_o` is 1 only for an accepted branch whose condition holds.
- R5: When `taken_o` is 1, `next_pc_o` equals `base_i` plus the zero-extended 16-bit `offset_i`, wrapping modulo 2^32.
- R6: For an accepted instruction that is not a taken branch, `next_pc_o` equals `pc_i` + 4, wrapping modulo 2^32. Op codes 2'b00 and 2'b11 are plain sequential operations.
- R7: When `instr_valid_i` is 0, `next_pc_o` equals `pc_i`, `taken_o` is 0 and the flags hold.
- R8: `halt_i` freezes the unit in the cycle it is high (`next_pc_o` = `pc_i`, `taken_o` = 0, no flag update). `halted_o` rises on the next cycle and stays high, with the same freeze, until reset.
- R9: A branch in the cycle right after a compare is decided on that compare's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | An instruction is presented this cycle |
| halt_i | input | 1 | Stop request, becomes sticky |
| op_i | input | 2 | 00 other, 01 compare, 10 branch, 11 other |
| cond_i | input | 3 | Branch condition code |
| opa_i | input | 32 | First compare operand |
| opb_i | input | 32 | Second compare operand |
| base_i | input | 32 | Branch base register value |
| offset_i | input | 16 | Branch offset, zero-extended |
| pc_i | input | 32 | Current program counter |
| next_pc_o | output | 32 | Program counter for the next instruction |
| taken_o | output | 1 | Branch taken this cycle |
| flags_o | output | 3 | Held flags: bit0 equal, bit1 greater, bit2 less |
| halted_o | output | 1 | Unit is halted |

## Verification
Operands with the top bit set are compared against small values. A signed comparator would report the opposite relation and set the wrong flag. Offsets of 0xFFFF on a base near the top of the address space and a PC of 0xFFFFFFFC check the wrap of both adders, which a sign-extended offset or a widened sum would get wrong. A branch placed straight after a compare catches flags that are read a cycle late. Branches, idle and halted cycles between compares show any flag update that leaks outside a compare. Code 7 and the sticky halt must never yield a taken branch or a moving counter.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam int NFLAG = 3;
  localparam int FL_EQ = 0;
  localparam int FL_GT = 1;
  localparam int FL_LT = 2;

  typedef enum logic [1:0] {
    OP_OTHER  = 2'b00,
    OP_CMP    = 2'b01,
    OP_BRANCH = 2'b10,
    OP_SPARE  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_EQ     = 3'd1,
    CC_NE     = 3'd2,
    CC_GT     = 3'd3,
    CC_GE     = 3'd4,
    CC_LT     = 3'd5,
    CC_LE     = 3'd6,
    CC_NEVER  = 3'd7
  } cond_e;

  function automatic logic cond_hit(input cond_e cc, input logic [NFLAG-1:0] fl);
    logic hit;
    case (cc)
      CC_ALWAYS: hit = 1'b1;
      CC_EQ:     hit = fl[FL_EQ];
      CC_NE:     hit = ~fl[FL_EQ];
      CC_GT:     hit = fl[FL_GT];
      CC_GE:     hit = fl[FL_GT] | fl[FL_EQ];
      CC_LT:     hit = fl[FL_LT];
      CC_LE:     hit = fl[FL_LT] | fl[FL_EQ];
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/cbr_relate.sv
module cbr_relate #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0]            a_i,
  input  logic [XLEN-1:0]            b_i,
  output logic [cbr_pkg::NFLAG-1:0]  rel_o
);
  localparam int LANES = XLEN / LANE_W;

  logic [LANES-1:0] lane_eq;
  logic [LANES-1:0] lane_gt;

  // Per-lane magnitude compare, resolved from the most significant lane down.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] sa;
    logic [LANE_W-1:0] sb;
    assign sa = a_i[g*LANE_W +: LANE_W];
    assign sb = b_i[g*LANE_W +: LANE_W];
    assign lane_eq[g] = (sa == sb);
    assign lane_gt[g] = (sa > sb);
  end

  logic eq_run;
  logic gt_run;

  always_comb begin
    eq_run = 1'b1;
    gt_run = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (eq_run && lane_gt[i]) gt_run = 1'b1;
      eq_run = eq_run & lane_eq[i];
    end
  end

  always_comb begin
    rel_o = '0;
    rel_o[cbr_pkg::FL_EQ] = eq_run;
    rel_o[cbr_pkg::FL_GT] = gt_run;
    rel_o[cbr_pkg::FL_LT] = ~eq_run & ~gt_run;
  end

endmodule

// File: rtl/cbr_state.sv
module cbr_state (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid_i,
  input  logic                       halt_i,
  input  logic                       is_cmp_i,
  input  logic [cbr_pkg::NFLAG-1:0]  rel_i,
  output logic                       accept_o,
  output logic                       halted_o,
  output logic [cbr_pkg::NFLAG-1:0]  flags_o
);
  logic                      halted_q, halted_d;
  logic [cbr_pkg::NFLAG-1:0] flags_q, flags_d;
  logic                      flags_en;

  assign accept_o = instr_valid_i & ~halt_i & ~halted_q;
  assign flags_en = accept_o & is_cmp_i;

  always_comb begin
    halted_d = halted_q | halt_i;
    flags_d  = flags_q;
    if (flags_en) flags_d = rel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      flags_q  <= '0;
    end else begin
      halted_q <= halted_d;
      if (flags_en) flags_q <= flags_d;
    end
  end

  assign halted_o = halted_q;
  assign flags_o  = flags_q;

endmodule

// File: rtl/cbr_condsel.sv
module cbr_condsel (
  input  logic [2:0]                 cond_i,
  input  logic [cbr_pkg::NFLAG-1:0]  flags_i,
  output logic                       hit_o
);
  localparam int NCOND = 8;

  logic [NCOND-1:0] hit_vec;

  for (genvar g = 0; g < NCOND; g++) begin : g_cc
    assign hit_vec[g] = cbr_pkg::cond_hit(cbr_pkg::cond_e'(g), flags_i);
  end

  assign hit_o = hit_vec[cond_i];

endmodule

// File: rtl/cbr_pcgen.sv
module cbr_pcgen #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int STEP  = 4
) (
  input  logic              accept_i,
  input  logic              take_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [XLEN-1:0]   next_pc_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] tgt_pc;

  assign seq_pc = pc_i + STEP_V;
  assign tgt_pc = base_i + {{(XLEN-OFS_W){1'b0}}, offset_i};

  always_comb begin
    if (!accept_i)   next_pc_o = pc_i;
    else if (take_i) next_pc_o = tgt_pc;
    else             next_pc_o = seq_pc;
  end

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit #(
  parameter int XLEN   = 32,
  parameter int OFS_W  = 16,
  parameter int STEP   = 4,
  parameter int LANE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid_i,
  input  logic               halt_i,
  input  logic [1:0]         op_i,
  input  logic [2:0]         cond_i,
  input  logic [XLEN-1:0]    opa_i,
  input  logic [XLEN-1:0]    opb_i,
  input  logic [XLEN-1:0]    base_i,
  input  logic [OFS_W-1:0]   offset_i,
  input  logic [XLEN-1:0]    pc_i,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               taken_o,
  output logic [2:0]         flags_o,
  output logic               halted_o
);
  import cbr_pkg::*;

  logic             is_cmp, is_br, accept, cc_hit, take;
  logic [NFLAG-1:0] rel, flags;

  assign is_cmp = (op_e'(op_i) == OP_CMP);
  assign is_br  = (op_e'(op_i) == OP_BRANCH);

  cbr_relate #(.XLEN(XLEN), .LANE_W(LANE_W)) u_rel (
    .a_i(opa_i), .b_i(opb_i), .rel_o(rel)
  );

  cbr_state u_st (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .halt_i(halt_i),
    .is_cmp_i(is_cmp), .rel_i(rel), .accept_o(accept), .halted_o(halted_o),
    .flags_o(flags)
  );

  cbr_condsel u_cc (.cond_i(cond_i), .flags_i(flags), .hit_o(cc_hit));

  assign take = accept & is_br & cc_hit;

  cbr_pcgen #(.XLEN(XLEN), .OFS_W(OFS_W), .STEP(STEP)) u_pc (
    .accept_i(accept), .take_i(take), .pc_i(pc_i), .base_i(base_i),
    .offset_i(offset_i), .next_pc_o(next_pc_o)
  );

  assign taken_o = take;
  assign flags_o = flags;

endmodule

// File: rtl/cbr_unit_chk.sv
module cbr_unit_chk #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid_i,
  input logic             halt_i,
  input logic [1:0]       op_i,
  input logic [XLEN-1:0]  pc_i,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             taken_o,
  input logic [2:0]       flags_o,
  input logic             halted_o
);
  logic acc_cmp;
  assign acc_cmp = instr_valid_i && !halt_i && !halted_o && (op_i == 2'b01);

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags_o)); // R2
  AST_CMP_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cmp |=> ($countones(flags_o) == 1)); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_cmp |=> $stable(flags_o)); // R3
  AST_TAKEN_BRANCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (instr_valid_i && op_i == 2'b10 && !halted_o)); // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && !halt_i && !halted_o && !taken_o) |-> (next_pc_o == pc_i + XLEN'(STEP))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i |-> (next_pc_o == pc_i && !taken_o)); // R7
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> halted_o); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i || halted_o) |-> (next_pc_o == pc_i && !taken_o)); // R8

endmodule

bind cbr_unit cbr_unit_chk #(.XLEN(XLEN), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .halt_i(halt_i),
  .op_i(op_i), .pc_i(pc_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
  .flags_o(flags_o), .halted_o(halted_o)
);

// File: tb/sim_cbr_unit.sv
`timescale 1ns/1ps
module sim_cbr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld, hlt;
  logic [1:0]  op;
  logic [2:0]  cc;
  logic [31:0] a, b, base, pc;
  logic [15:0] ofs;
  logic [31:0] npc;
  logic        tkn;
  logic [2:0]  fl;
  logic        hd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [2:0] m_fl;
  logic       m_hd;
  bit         last_cmp;

  always #10 clk = ~clk;

  cbr_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(vld), .halt_i(hlt), .op_i(op),
    .cond_i(cc), .opa_i(a), .opb_i(b), .base_i(base), .offset_i(ofs), .pc_i(pc),
    .next_pc_o(npc), .taken_o(tkn), .flags_o(fl), .halted_o(hd)
  );

  function automatic logic [2:0] rel_of(input logic [31:0] x, input logic [31:0] y);
    if (x == y) return 3'b001;
    if (x > y)  return 3'b010;
    return 3'b100;
  endfunction

  function automatic logic hit_of(input logic [2:0] c, input logic [2:0] f);
    case (c)
      3'd0: return 1'b1;
      3'd1: return f[0];
      3'd2: return !f[0];
      3'd3: return f[1];
      3'd4: return f[1] | f[0];
      3'd5: return f[2];
      3'd6: return f[2] | f[0];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one instruction, check outputs mid-cycle, update model at the edge.
  task automatic step(input logic v, input logic h, input logic [1:0] o, input logic [2:0] c,
                      input logic [31:0] xa, input logic [31:0] xb, input logic [31:0] xbase,
                      input logic [15:0] xofs, input logic [31:0] xpc, input string note);
    logic acc, etk;
    logic [31:0] enpc;
    vld = v; hlt = h; op = o; cc = c; a = xa; b = xb; base = xbase; ofs = xofs; pc = xpc;
    @(negedge clk);
    acc  = v && !h && !m_hd;
    etk  = acc && (o == 2'b10) && hit_of(c, m_fl);
    enpc = !acc ? xpc : (etk ? xbase + {16'h0, xofs} : xpc + 32'd4);
    chk({note, (o == 2'b10) ? " R4 taken" : " R4 not-branch taken"}, {31'h0, tkn}, {31'h0, etk});
    chk({note, !v ? " R7 pc" : (h || m_hd) ? " R8 pc" : etk ? " R5 pc" : " R6 pc"}, npc, enpc);
    chk({note, last_cmp ? " R2 flags" : " R3 flags"}, {29'h0, fl}, {29'h0, m_fl});
    chk({note, " R8 halted"}, {31'h0, hd}, {31'h0, m_hd});
    @(posedge clk);
    if (acc && o == 2'b01) m_fl = rel_of(xa, xb);
    last_cmp = acc && (o == 2'b01);
    if (h) m_hd = 1'b1;
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vld = 0; hlt = 0; op = 0; cc = 0; a = 0; b = 0; base = 0; ofs = 0; pc = 0;
    m_fl = 3'b000; m_hd = 1'b0; last_cmp = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 flags in reset", {29'h0, fl}, 32'h0);
    chk("R1 halted in reset", {31'h0, hd}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", {29'h0, fl}, 32'h0);
    chk("R1 halted after reset", {31'h0, hd}, 32'h0);
    @(posedge clk);
    #2;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();

    // Directed corner cases
    step(1, 0, 2'b01, 0, 32'h8000_0000, 32'h1, 0, 0, 32'h100, "R2 unsigned top bit");
    step(1, 0, 2'b10, 3'd3, 0, 0, 32'h2000, 16'h10, 32'h104, "R9 gt after cmp");
    step(1, 0, 2'b01, 0, 32'd5, 32'd9, 0, 0, 32'h108, "R2 less");
    step(1, 0, 2'b10, 3'd5, 0, 0, 32'hFFFF_FFF0, 16'hFFFF, 32'h10C, "R5 R9 wrap target");
    step(1, 0, 2'b10, 3'd7, 0, 0, 32'h40, 16'h4, 32'h110, "R4 never");
    step(1, 0, 2'b00, 0, 32'd1, 32'd1, 0, 0, 32'hFFFF_FFFC, "R6 pc wrap");
    step(1, 0, 2'b11, 0, 32'd1, 32'd1, 0, 0, 32'h200, "R3 spare op");
    step(0, 0, 2'b01, 0, 32'd3, 32'd3, 0, 0, 32'h300, "R7 idle cmp");
    step(1, 0, 2'b01, 0, 32'hABCD, 32'hABCD, 0, 0, 32'h304, "R2 equal");
    step(1, 0, 2'b10, 3'd2, 0, 0, 32'h10, 16'h8, 32'h308, "R4 ne");
    step(1, 0, 2'b10, 3'd4, 0, 0, 32'h10, 16'h8, 32'h30C, "R4 ge");
    step(1, 0, 2'b10, 3'd6, 0, 0, 32'h10, 16'h8, 32'h310, "R4 le");

    // Constrained random
    for (int i = 0; i < 800; i++) begin
      logic [31:0] ra, rb;
      logic [1:0]  ro;
      ra = $urandom;
      case ($urandom % 4)
        0: rb = ra;
        1: rb = ra ^ (32'h1 << ($urandom % 32));
        default: rb = $urandom;
      endcase
      ro = ($urandom % 3 == 0) ? 2'b01 : (($urandom % 2) ? 2'b10 : 2'(($urandom % 2) * 3));
      step(($urandom % 8) != 0, 1'b0, ro, 3'($urandom), ra, rb, $urandom,
           16'($urandom), $urandom, "rnd");
    end

    // Halt and freeze
    step(1, 1, 2'b10, 3'd0, 0, 0, 32'h500, 16'h20, 32'h400, "R8 halt cycle");
    step(1, 0, 2'b01, 0, 32'd1, 32'd2, 0, 0, 32'h404, "R8 halted cmp");
    step(1, 0, 2'b10, 3'd0, 0, 0, 32'h500, 16'h20, 32'h408, "R8 halted branch");
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 32'h40C, "R8 halted seq");

    do_reset();
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 32'h0, "R1 runs after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

endmodule